// File: doc/BRIEF.md
# Interrupt Controller Configuration Register File

This block is the software-visible configuration store of a per-core interrupt controller. A simple request bus (valid, write flag, 12-bit byte offset, 32-bit data) reads and writes 32-bit registers placed on 16-byte boundaries inside a 4 KB window. The block does not count time and does not arbitrate interrupts. It holds the settings that the timer and the arbitration logic next to it consume, and drives every stored value out on its own port.

Each register applies its own write rule. Some fields are trimmed, some are forced to ones, some are read-only, and two registers cannot be written at all. The error status register needs a two-step write to clear. Any access that falls outside the implemented map changes no state. It sets a sticky bus error flag instead, and a read of such an offset returns zero.

Top module: `irq_cfg_regfile`

## Requirements
- R1: A read request produces `rsp_valid` high together with its data on the cycle after the request edge. Cycles with no read request, including write cycles, leave `rsp_valid` low.
- R2: Decoding ignores address bits 2:0. The register offsets are: identity 0x020, version 0x030, task priority 0x080, logical destination 0x0D0, destination format 0x0E0, spurious vector 0x0F0, error status 0x280, vector entries k=0..5 at 0x320+0x10*k, initial count 0x380, current count 0x390, divide configuration 0x3E0.
- R3: Identity and task priority store only write bits 7:0. Logical destination stores only bits 31:24, and bits 23:0 read as zero. A destination format write stores the data with bits 27:0 forced to one.
- R4: Version always reads the `VERSION_VAL` parameter. Current count always reads `cur_count_in`. Writes to either offset change nothing.
- R5: In every vector entry, bits 12 and 14 follow `lvt_hw_status` bits 2k and 2k+1, one cycle late. A write cannot change these two bits. All other bits take the written value.
- R6: A divide configuration write stores data AND 0xB. `out_div_shift` is ((b3*4 + b1*2 + b0) + 1) mod 8, so the timer divides by 2^shift.
- R7: An error status write while disarmed only arms an internal flag. A write while armed clears the register to zero and disarms the flag. A read of error status disarms the flag. `err_report` bits are ORed into the register every cycle.
- R8: A spurious vector write stores all 32 bits and copies data bit 8 into `out_sw_enable`.
- R9: An access to any offset not listed in R2 sets `bus_err`, which stays set until reset. The access leaves all registers unchanged, and a read of such an offset returns zero.
- R10: After reset: identity, task priority, logical destination, error status, initial count and divide configuration are 0; destination format is 0xFFFFFFFF; spurious vector is 0x000000FF with software enable off; each vector entry is 0x00010000; `out_div_shift` is 1; `bus_err` and `rsp_valid` are low.
- R11: Initial count stores all 32 written bits and drives them on `out_init_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| bus_err | output | 1 | Sticky bad-offset flag |
| cur_count_in | input | 32 | Live count from the timer |
| lvt_hw_status | input | 2*LVT_N | Status bits for vector entries |
| err_report | input | ERR_W | Error events to accumulate |
| out_id | output | 8 | Identity value |
| out_task_prio | output | 8 | Task priority |
| out_logic_dest | output | 32 | Logical destination |
| out_dest_fmt | output | 32 | Destination format |
| out_spur_vec | output | 32 | Spurious vector register |
| out_sw_enable | output | 1 | Software enable state |
| out_lvt | output | 32*LVT_N | Vector entries, entry k at bits 32k+31:32k |
| out_err_stat | output | 32 | Error status |
| out_init_count | output | 32 | Timer initial count |
| out_div_cfg | output | 4 | Divide configuration |
| out_div_shift | output | 3 | Divide ratio exponent |

## Verification
All-ones and random data are written to every register. This separates registers that trim bits, force bits to one, or freeze bits from registers that store the whole word. Addresses carry random low bits and random high offsets, which shows whether decoding ignores bits 2:0 and rejects offsets that are near a valid one but misaligned. All sixteen divide codes are driven to cover the shift mapping. Directed sequences (write-write, write-read-write-write, and a report pulse) separate correct arm and clear ordering from a single-write clear.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int RO_LO  = 12;
  localparam int RO_HI  = 14;

  localparam logic [ADDR_W-1:0] OFF_ID   = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_VER  = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_TPR  = 12'h080;
  localparam logic [ADDR_W-1:0] OFF_LDST = 12'h0D0;
  localparam logic [ADDR_W-1:0] OFF_DFMT = 12'h0E0;
  localparam logic [ADDR_W-1:0] OFF_SPUR = 12'h0F0;
  localparam logic [ADDR_W-1:0] OFF_ESTA = 12'h280;
  localparam logic [ADDR_W-1:0] OFF_LVT0 = 12'h320;
  localparam logic [ADDR_W-1:0] OFF_INIT = 12'h380;
  localparam logic [ADDR_W-1:0] OFF_CUR  = 12'h390;
  localparam logic [ADDR_W-1:0] OFF_DIV  = 12'h3E0;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_VER, SEL_TPR, SEL_LDST, SEL_DFMT,
    SEL_SPUR, SEL_ESTA, SEL_LVT, SEL_INIT, SEL_CUR, SEL_DIV
  } reg_sel_e;
endpackage

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import irq_cfg_pkg::*;
#(
  parameter int LVT_N  = 6,
  localparam int LVT_IW = (LVT_N > 1) ? $clog2(LVT_N) : 1
) (
  input  logic [ADDR_W-4:0]  addr_hi,
  output reg_sel_e           sel,
  output logic [LVT_IW-1:0]  lvt_idx,
  output logic               hit
);
  logic [ADDR_W-1:0] off;
  assign off = {addr_hi, 3'b000};

  always_comb begin
    sel     = SEL_NONE;
    lvt_idx = '0;
    if (off[3] == 1'b0) begin
      if      (off == OFF_ID)   sel = SEL_ID;
      else if (off == OFF_VER)  sel = SEL_VER;
      else if (off == OFF_TPR)  sel = SEL_TPR;
      else if (off == OFF_LDST) sel = SEL_LDST;
      else if (off == OFF_DFMT) sel = SEL_DFMT;
      else if (off == OFF_SPUR) sel = SEL_SPUR;
      else if (off == OFF_ESTA) sel = SEL_ESTA;
      else if (off == OFF_INIT) sel = SEL_INIT;
      else if (off == OFF_CUR)  sel = SEL_CUR;
      else if (off == OFF_DIV)  sel = SEL_DIV;
      else if (off >= OFF_LVT0 && off < OFF_LVT0 + ADDR_W'(LVT_N * 16)) begin
        sel     = SEL_LVT;
        lvt_idx = LVT_IW'((off - OFF_LVT0) >> 4);
      end
    end
  end

  assign hit = (sel != SEL_NONE);

  // R2: a decoded vector entry index never exceeds the entry count
  always_comb begin
    p_lvt_idx_range_r2: assert (sel != SEL_LVT || int'(lvt_idx) < LVT_N);
  end
endmodule

// File: rtl/irq_cfg_lvt_entry.sv
module irq_cfg_lvt_entry
  import irq_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hw_lo,
  input  logic              hw_hi,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RESET_VAL;
    end else begin
      if (we) q <= wdata;
      q[RO_LO] <= hw_lo;
      q[RO_HI] <= hw_hi;
    end
  end

  p_ro_bits_r5: assert property (@(posedge clk) disable iff (rst)
    we |=> (q[RO_LO] == $past(hw_lo)) && (q[RO_HI] == $past(hw_hi)));
endmodule

// File: rtl/irq_cfg_err.sv
module irq_cfg_err #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [ERR_W-1:0] report,
  output logic [ERR_W-1:0] stat
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      stat  <= '0;
    end else begin
      if (wr && armed) begin
        stat  <= report;
        armed <= 1'b0;
      end else begin
        stat <= stat | report;
        if (wr)      armed <= 1'b1;
        else if (rd) armed <= 1'b0;
      end
    end
  end

  p_clear_when_armed_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && armed) |=> (stat == $past(report)));
  p_first_write_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && !armed) |=> (stat == ($past(stat) | $past(report))));
endmodule

// File: rtl/irq_cfg_regfile.sv
module irq_cfg_regfile
  import irq_cfg_pkg::*;
#(
  parameter int                LVT_N       = 6,
  parameter int                ERR_W       = 8,
  parameter logic [DATA_W-1:0] VERSION_VAL = 32'h0005_0014
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  bus_err,
  input  logic [DATA_W-1:0]     cur_count_in,
  input  logic [2*LVT_N-1:0]    lvt_hw_status,
  input  logic [ERR_W-1:0]      err_report,
  output logic [7:0]            out_id,
  output logic [7:0]            out_task_prio,
  output logic [DATA_W-1:0]     out_logic_dest,
  output logic [DATA_W-1:0]     out_dest_fmt,
  output logic [DATA_W-1:0]     out_spur_vec,
  output logic                  out_sw_enable,
  output logic [DATA_W*LVT_N-1:0] out_lvt,
  output logic [DATA_W-1:0]     out_err_stat,
  output logic [DATA_W-1:0]     out_init_count,
  output logic [3:0]            out_div_cfg,
  output logic [2:0]            out_div_shift
);
  localparam int LVT_IW = (LVT_N > 1) ? $clog2(LVT_N) : 1;

  reg_sel_e          sel;
  logic [LVT_IW-1:0] lvt_idx;
  logic              hit;
  logic              unused_lo_bits;
  assign unused_lo_bits = ^req_addr[2:0];

  irq_cfg_decode #(.LVT_N(LVT_N)) u_decode (
    .addr_hi (req_addr[ADDR_W-1:3]),
    .sel     (sel),
    .lvt_idx (lvt_idx),
    .hit     (hit)
  );

  logic do_wr, do_rd;
  assign do_wr = req_valid && req_write && hit;
  assign do_rd = req_valid && !req_write;

  // vector table entries
  logic [DATA_W-1:0] lvt_q [LVT_N];
  for (genvar k = 0; k < LVT_N; k++) begin : g_lvt
    irq_cfg_lvt_entry u_entry (
      .clk   (clk),
      .rst   (rst),
      .we    (do_wr && sel == SEL_LVT && int'(lvt_idx) == k),
      .wdata (req_wdata),
      .hw_lo (lvt_hw_status[2*k]),
      .hw_hi (lvt_hw_status[2*k+1]),
      .q     (lvt_q[k])
    );
    assign out_lvt[DATA_W*k +: DATA_W] = lvt_q[k];
  end

  // error status
  logic [ERR_W-1:0] err_q;
  irq_cfg_err #(.ERR_W(ERR_W)) u_err (
    .clk    (clk),
    .rst    (rst),
    .wr     (do_wr && sel == SEL_ESTA),
    .rd     (req_valid && !req_write && hit && sel == SEL_ESTA),
    .report (err_report),
    .stat   (err_q)
  );
  assign out_err_stat = DATA_W'(err_q);

  // plain registers with per-register write rules
  always_ff @(posedge clk) begin
    if (rst) begin
      out_id         <= '0;
      out_task_prio  <= '0;
      out_logic_dest <= '0;
      out_dest_fmt   <= '1;
      out_spur_vec   <= 32'h0000_00FF;
      out_sw_enable  <= 1'b0;
      out_init_count <= '0;
      out_div_cfg    <= '0;
      out_div_shift  <= 3'd1;
    end else if (do_wr) begin
      case (sel)
        SEL_ID:   out_id         <= req_wdata[7:0];
        SEL_TPR:  out_task_prio  <= req_wdata[7:0];
        SEL_LDST: out_logic_dest <= {req_wdata[31:24], 24'h0};
        SEL_DFMT: out_dest_fmt   <= req_wdata | 32'h0FFF_FFFF;
        SEL_SPUR: begin
          out_spur_vec  <= req_wdata;
          out_sw_enable <= req_wdata[8];
        end
        SEL_INIT: out_init_count <= req_wdata;
        SEL_DIV: begin
          out_div_cfg   <= req_wdata[3:0] & 4'hB;
          out_div_shift <= {req_wdata[3], req_wdata[1:0]} + 3'd1;
        end
        default: ;
      endcase
    end
  end

  // read path
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    case (sel)
      SEL_ID:   rd_mux = DATA_W'(out_id);
      SEL_VER:  rd_mux = VERSION_VAL;
      SEL_TPR:  rd_mux = DATA_W'(out_task_prio);
      SEL_LDST: rd_mux = out_logic_dest;
      SEL_DFMT: rd_mux = out_dest_fmt;
      SEL_SPUR: rd_mux = out_spur_vec;
      SEL_ESTA: rd_mux = out_err_stat;
      SEL_LVT:  rd_mux = lvt_q[lvt_idx];
      SEL_INIT: rd_mux = out_init_count;
      SEL_CUR:  rd_mux = cur_count_in;
      SEL_DIV:  rd_mux = DATA_W'(out_div_cfg);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      rsp_valid <= do_rd;
      if (do_rd) rsp_rdata <= rd_mux;
      if (req_valid && !hit) bus_err <= 1'b1;
    end
  end

  p_rsp_after_read_r1: assert property (@(posedge clk) disable iff (rst)
    do_rd |=> rsp_valid);
  p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !do_rd |=> !rsp_valid);
  p_bad_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit) |=> bus_err);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> bus_err);
  p_bad_no_change_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !hit) |=>
      $stable(out_task_prio) && $stable(out_init_count) && $stable(out_spur_vec));
  p_bad_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !hit) |=> (rsp_rdata == '0));
  p_sw_enable_r8: assert property (@(posedge clk) disable iff (rst)
    (do_wr && sel == SEL_SPUR) |=> (out_sw_enable == $past(req_wdata[8])));
  p_ldst_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (do_wr && sel == SEL_LDST) |=> (out_logic_dest[23:0] == 24'h0));
endmodule

// File: tb/irq_cfg_regfile_tb.sv
`timescale 1ns/1ps
module irq_cfg_regfile_tb;
  localparam int LVT_N = 6;
  localparam int ERR_W = 8;
  localparam logic [31:0] VER = 32'h0005_0014;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata, cur_count_in;
  logic [2*LVT_N-1:0] lvt_hw;
  logic [ERR_W-1:0] err_report;
  logic rsp_valid, bus_err, out_sw_enable;
  logic [31:0] rsp_rdata, out_logic_dest, out_dest_fmt, out_spur_vec, out_err_stat, out_init_count;
  logic [7:0] out_id, out_task_prio;
  logic [32*LVT_N-1:0] out_lvt;
  logic [3:0] out_div_cfg;
  logic [2:0] out_div_shift;

  irq_cfg_regfile #(.LVT_N(LVT_N), .ERR_W(ERR_W), .VERSION_VAL(VER)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_err(bus_err), .cur_count_in(cur_count_in),
    .lvt_hw_status(lvt_hw), .err_report(err_report), .out_id(out_id),
    .out_task_prio(out_task_prio), .out_logic_dest(out_logic_dest),
    .out_dest_fmt(out_dest_fmt), .out_spur_vec(out_spur_vec),
    .out_sw_enable(out_sw_enable), .out_lvt(out_lvt), .out_err_stat(out_err_stat),
    .out_init_count(out_init_count), .out_div_cfg(out_div_cfg),
    .out_div_shift(out_div_shift));

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [7:0]  m_id, m_tpr, m_err;
  logic [31:0] m_ldst, m_dfmt, m_spur, m_init;
  logic        m_sw, m_armed, m_berr;
  logic [3:0]  m_div;
  logic [31:0] m_lvt [LVT_N];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_legal(input logic [11:0] a);
    logic [11:0] b;
    b = {a[11:4], 4'h0};
    if (a[3]) return 0;
    if (b == 12'h020 || b == 12'h030 || b == 12'h080 || b == 12'h0D0 || b == 12'h0E0 ||
        b == 12'h0F0 || b == 12'h280 || b == 12'h380 || b == 12'h390 || b == 12'h3E0) return 1;
    return (b >= 12'h320 && b <= 12'h370);
  endfunction

  function automatic logic [31:0] lvt_view(input int k);
    logic [31:0] v;
    v = m_lvt[k] & ~32'h0000_5000;
    v[12] = lvt_hw[2*k];
    v[14] = lvt_hw[2*k+1];
    return v;
  endfunction

  function automatic logic [2:0] shift_of(input logic [3:0] v);
    int code;
    code = ((v & 4'h8) != 0 ? 4 : 0) + int'(v & 4'h3);
    return 3'((code + 1) % 8);
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [11:0] b;
    b = {a[11:4], 4'h0};
    if (!is_legal(a)) return 32'h0;
    case (b)
      12'h020: return {24'h0, m_id};
      12'h030: return VER;
      12'h080: return {24'h0, m_tpr};
      12'h0D0: return m_ldst;
      12'h0E0: return m_dfmt;
      12'h0F0: return m_spur;
      12'h280: return {24'h0, m_err};
      12'h380: return m_init;
      12'h390: return cur_count_in;
      12'h3E0: return {28'h0, m_div};
      default: return lvt_view(int'((b - 12'h320) >> 4));
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    logic [11:0] b;
    b = {a[11:4], 4'h0};
    if (!is_legal(a)) begin m_berr = 1; return; end
    case (b)
      12'h020: m_id = d[7:0];
      12'h080: m_tpr = d[7:0];
      12'h0D0: m_ldst = d & 32'hFF00_0000;
      12'h0E0: m_dfmt = d | 32'h0FFF_FFFF;
      12'h0F0: begin m_spur = d; m_sw = d[8]; end
      12'h280: if (m_armed) begin m_err = 0; m_armed = 0; end else m_armed = 1;
      12'h380: m_init = d;
      12'h3E0: m_div = d[3:0] & 4'b1011;
      12'h030, 12'h390: ;
      default: m_lvt[int'((b - 12'h320) >> 4)] = d;
    endcase
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    model_write(a, d);
    chk(rsp_valid == 0, "R1 no rsp on write", 32'(rsp_valid), 0);
  endtask

  task automatic bus_read(input logic [11:0] a, input string req);
    logic [31:0] e;
    e = exp_read(a);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (!is_legal(a)) m_berr = 1;
    else if ({a[11:4], 4'h0} == 12'h280) m_armed = 0;
    chk(rsp_valid == 1, "R1 rsp_valid", 32'(rsp_valid), 1);
    chk(rsp_rdata == e, req, rsp_rdata, e);
  endtask

  task automatic check_outputs(input string tag);
    chk(out_id == m_id, {tag, " R3 id"}, 32'(out_id), 32'(m_id));
    chk(out_task_prio == m_tpr, {tag, " R3 tpr"}, 32'(out_task_prio), 32'(m_tpr));
    chk(out_logic_dest == m_ldst, {tag, " R3 ldst"}, out_logic_dest, m_ldst);
    chk(out_dest_fmt == m_dfmt, {tag, " R3 dfmt"}, out_dest_fmt, m_dfmt);
    chk(out_spur_vec == m_spur, {tag, " R8 spur"}, out_spur_vec, m_spur);
    chk(out_sw_enable == m_sw, {tag, " R8 sw_enable"}, 32'(out_sw_enable), 32'(m_sw));
    chk(out_init_count == m_init, {tag, " R11 init"}, out_init_count, m_init);
    chk(out_div_cfg == m_div, {tag, " R6 div"}, 32'(out_div_cfg), 32'(m_div));
    chk(out_div_shift == shift_of(m_div), {tag, " R6 shift"}, 32'(out_div_shift), 32'(shift_of(m_div)));
    chk(out_err_stat == {24'h0, m_err}, {tag, " R7 err"}, out_err_stat, {24'h0, m_err});
    chk(bus_err == m_berr, {tag, " R9 bus_err"}, 32'(bus_err), 32'(m_berr));
    for (int k = 0; k < LVT_N; k++)
      chk(out_lvt[32*k +: 32] == lvt_view(k), {tag, " R5 lvt"}, out_lvt[32*k +: 32], lvt_view(k));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] a;
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst = 1; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    cur_count_in = 32'h1234_5678; lvt_hw = '0; err_report = '0;
    m_id = 0; m_tpr = 0; m_err = 0; m_ldst = 0; m_dfmt = '1; m_spur = 32'hFF;
    m_init = 0; m_sw = 0; m_armed = 0; m_berr = 0; m_div = 0;
    for (int k = 0; k < LVT_N; k++) m_lvt[k] = 32'h0001_0000;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk(rsp_valid == 0, "R10 rsp_valid reset", 32'(rsp_valid), 0);
    check_outputs("R10 reset");
    // R4 read-only registers
    bus_read(12'h030, "R4 version read");
    bus_write(12'h030, 32'hDEAD_BEEF);
    bus_read(12'h034, "R4 version after write");
    bus_write(12'h390, 32'hCAFE_0000);
    bus_read(12'h390, "R4 current count");
    cur_count_in = 32'h0BAD_F00D;
    bus_read(12'h397, "R4 current count follows input");
    // R3 trimmed / forced registers, R2 low bits ignored
    bus_write(12'h027, 32'hFFFF_FFA5);
    bus_read(12'h020, "R2 R3 id via low bits");
    bus_write(12'h080, 32'h1234_5678);
    bus_write(12'h0D0, 32'hABCD_EF01);
    bus_write(12'h0E0, 32'h0000_0000);
    bus_read(12'h0D4, "R3 logical dest");
    bus_read(12'h0E0, "R3 dest format");
    check_outputs("R3");
    // R5 vector entries
    lvt_hw = 12'b1010_0110_0101;
    @(negedge clk);
    bus_write(12'h320, 32'hFFFF_FFFF);
    bus_write(12'h370, 32'h0000_0000);
    bus_read(12'h320, "R5 entry0 ro bits");
    bus_read(12'h370, "R5 entry5 ro bits");
    check_outputs("R5");
    // R6 all divide codes
    for (int v = 0; v < 16; v++) begin
      bus_write(12'h3E0, 32'hFFFF_FFF0 | 32'(v));
      chk(out_div_shift == shift_of(4'(v)), "R6 shift code", 32'(out_div_shift), 32'(shift_of(4'(v))));
      chk(out_div_cfg == (4'(v) & 4'hB), "R6 div mask", 32'(out_div_cfg), 32'(4'(v) & 4'hB));
    end
    // R7 arm / clear sequences
    err_report = 8'h05; @(negedge clk); err_report = 0; m_err = 8'h05;
    chk(out_err_stat == 32'h5, "R7 report accumulates", out_err_stat, 32'h5);
    bus_write(12'h280, 32'h0);
    chk(out_err_stat == 32'h5, "R7 first write arms only", out_err_stat, 32'h5);
    bus_read(12'h280, "R7 read disarms");
    bus_write(12'h280, 32'h0);
    chk(out_err_stat == 32'h5, "R7 rearm after read keeps value", out_err_stat, 32'h5);
    bus_write(12'h280, 32'h0);
    chk(out_err_stat == 32'h0, "R7 second write clears", out_err_stat, 32'h0);
    // R8 spurious
    bus_write(12'h0F0, 32'h0000_01AB);
    chk(out_sw_enable == 1, "R8 enable set", 32'(out_sw_enable), 1);
    bus_write(12'h0F0, 32'hFFFF_FEFF);
    chk(out_sw_enable == 0, "R8 enable clear", 32'(out_sw_enable), 0);
    // R11 initial count
    bus_write(12'h380, 32'h8000_0001);
    bus_read(12'h380, "R11 init readback");
    check_outputs("R8 R11");
    // R9 illegal offsets
    chk(bus_err == 0, "R9 no error yet", 32'(bus_err), 0);
    bus_write(12'h100, 32'hFFFF_FFFF);
    bus_write(12'h088, 32'hFFFF_FFFF);
    bus_read(12'h200, "R9 array read zero");
    bus_read(12'h090, "R9 reserved read zero");
    bus_read(12'h3F0, "R9 unmapped read zero");
    check_outputs("R9");
    // random phase
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        lvt_hw = 12'($urandom);
        cur_count_in = $urandom;
        @(negedge clk);
      end
      if ($urandom_range(0, 9) == 0) a = 12'($urandom);
      else begin
        case ($urandom_range(0, 16))
          0: a = 12'h020; 1: a = 12'h030; 2: a = 12'h080; 3: a = 12'h0D0;
          4: a = 12'h0E0; 5: a = 12'h0F0; 6: a = 12'h280; 7: a = 12'h380;
          8: a = 12'h390; 9: a = 12'h3E0;
          default: a = 12'h320 + 12'(16 * $urandom_range(0, LVT_N - 1));
        endcase
        a[2:0] = 3'($urandom);
      end
      d = $urandom;
      if ($urandom_range(0, 1) == 1) bus_write(a, d);
      else bus_read(a, "R2 random read");
      if (i % 50 == 0) check_outputs("R2 random");
    end
    check_outputs("final");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule